// File: doc/BRIEF.md
# Dual-Channel PCM Serial Port with Load Strobe

This block is the serial front end for a pair of 8-bit mu-law PCM channels. Channel A carries the send-path sample and channel B the return-path sample. Both channels share one external bit clock and one 8 kHz frame sync. The bit clock and the sync are brought into the system clock domain, and every register in the block runs on the system clock. On the capture side, the block shifts one byte from each serial input line. Once both bytes are complete, it presents them as parallel words and raises a load strobe one bit period wide. That strobe starts the processing cycle downstream.

On the send side, the block loads two processed bytes at the start of each frame and shifts them out MSB first on two serial lines. A drive-enable output is high only while the eight data bits are on the lines. An external pad turns that enable into a high-impedance state. A pass-through mode replaces the processed bytes with the bytes captured in the previous frame, copied exactly with no code conversion. Reset and a power-down request both keep the lines released.

Top module: `pcm_serial_port`

## Requirements
- R1: During and after synchronous reset (rst_n low), ser_oe and load_stb are 0 and par_a and par_b are 0.
- R2: Input bits are sampled on bit-clock falling edges, MSB first. The first fall after a frame start gives bit 7 and the eighth fall gives bit 0. After the eighth fall, par_a holds the byte from ser_in_a and par_b holds the byte from ser_in_b.
- R3: load_stb rises on the falling edge that samples bit 0 and falls on the next falling edge, so it is high for exactly one bit-clock period.
- R4: par_a and par_b change only when load_stb rises. They hold their value from one strobe to the next.
- R5: A frame starts at a bit-clock rising edge where frame_sync is 1 and was 0 at the previous rising edge. A sync held high for longer does not start the frame again.
- R6: From the frame-start rising edge, bit 7 of each outgoing byte is driven, and each later rising edge presents the next lower bit. ser_oe is 1 for exactly those eight bit periods. ser_out_a carries channel A and ser_out_b carries channel B.
- R7: ser_oe falls at the rising edge after bit 0 and stays 0 through idle bit periods until the next frame start.
- R8: through_en is sampled at frame start. When it is 1, the outgoing bytes are the par_a/par_b values captured in the previous frame, copied bit for bit, including 8'hFF. When it is 0, the outgoing bytes are proc_a/proc_b.
- R9: While pd_req is 1, ser_oe and load_stb are 0 from the next clock on, and the frame in progress is dropped: no capture occurs and par_a and par_b are unchanged. Normal operation resumes at the next frame start after release.
- R10: Framing is correct for any bit clock whose high and low phases each last at least 3 system-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req | input | 1 | Power-down request, active high |
| bit_clk | input | 1 | External PCM bit clock (asynchronous) |
| frame_sync | input | 1 | External 8 kHz frame sync (asynchronous) |
| through_en | input | 1 | Pass-through select, sampled at frame start |
| ser_in_a | input | 1 | Send-path serial input |
| ser_in_b | input | 1 | Return-path serial input |
| proc_a | input | 8 | Processed byte for channel A output |
| proc_b | input | 8 | Processed byte for channel B output |
| par_a | output | 8 | Captured channel A byte |
| par_b | output | 8 | Captured channel B byte |
| load_stb | output | 1 | Load strobe, one bit period wide |
| ser_out_a | output | 1 | Channel A serial output data |
| ser_out_b | output | 1 | Channel B serial output data |
| ser_oe | output | 1 | Output drive enable; 0 means the lines float |

## Verification
The assertions check four rules on every cycle. The output lines and the enable change only at a synchronised bit-clock rise. The strobe changes only at a fall. The parallel words move only when the strobe rises. Power-down silences the outputs one clock later. The bench scenarios are what show the actual values: the bit order and byte contents on both channels, the exact strobe width in system clocks, pass-through of captured codes including FF, the release after bit 0, that a long sync does not restart the frame, and a frame aborted midway by power-down. Each is run at several bit-clock ratios.

// File: rtl/pcm_port_pkg.sv
// Package: constants and types shared by the PCM serial port modules.
// Assumes two channels of 8-bit samples.
package pcm_port_pkg;
    parameter int PCM_W   = 8;   // bits per sample
    parameter int PCM_NCH = 2;   // channels: 0 = A (send path), 1 = B (return path)

    typedef logic [PCM_W-1:0] pcm_word_t;
endpackage

// File: rtl/pcm_sync_chain.sv
// Module: multi-bit, multi-stage synchroniser for asynchronous level inputs.
// Assumes each bit is an independent slow level (bit clock, frame sync),
// so per-bit synchronisation without a common handshake is adequate.
module pcm_sync_chain #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pcm_rx_deser.sv
// Module: capture side. Shifts one byte per channel on bit-clock falls after a
// frame start, then publishes the parallel words and raises the load strobe
// until the next fall. Assumes start and bit_fall never coincide
// (they come from opposite bit-clock edges).
module pcm_rx_deser
    import pcm_port_pkg::*;
#(
    parameter int W   = PCM_W,
    parameter int NCH = PCM_NCH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   halt,
    input  logic                   start,
    input  logic                   bit_fall,
    input  logic [NCH-1:0]         sin,
    output logic [NCH-1:0][W-1:0]  par_out,
    output logic                   load_stb
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] bits_left;
    logic          armed;
    logic          shift_en;
    logic          last_bit;

    // Shift qualifiers shared by all channels.
    always_comb begin
        shift_en = !halt && !start && bit_fall && armed;
        last_bit = shift_en && (bits_left == CW'(1));
    end

    // Frame control: arm on start, count samples, raise and drop the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_left <= '0;
            armed     <= 1'b0;
            load_stb  <= 1'b0;
        end else if (halt) begin
            bits_left <= '0;
            armed     <= 1'b0;
            load_stb  <= 1'b0;
        end else if (start) begin
            bits_left <= CW'(W);
            armed     <= 1'b1;
        end else if (bit_fall) begin
            load_stb <= last_bit;
            if (armed) begin
                bits_left <= bits_left - CW'(1);
                armed     <= !last_bit;
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [W-1:0] shreg;

        // Per-channel shift register and parallel word update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg      <= '0;
                par_out[c] <= '0;
            end else if (shift_en) begin
                shreg <= {shreg[W-2:0], sin[c]};
                if (last_bit) begin
                    par_out[c] <= {shreg[W-2:0], sin[c]};
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tx_ser.sv
// Module: send side. Loads one byte per channel at frame start (processed or
// previously captured, per the pass-through select) and shifts it out MSB first
// on bit-clock rises. The drive enable covers exactly W bit periods.
// Assumes start is a subset of bit_rise.
module pcm_tx_ser
    import pcm_port_pkg::*;
#(
    parameter int W   = PCM_W,
    parameter int NCH = PCM_NCH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   halt,
    input  logic                   start,
    input  logic                   bit_rise,
    input  logic                   thr_en,
    input  logic [NCH-1:0][W-1:0]  proc_word,
    input  logic [NCH-1:0][W-1:0]  cap_word,
    output logic [NCH-1:0]         sout,
    output logic                   oe
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] bits_left;
    logic          load_en;
    logic          shift_en;

    // Load and shift qualifiers shared by all channels.
    always_comb begin
        load_en  = !halt && start;
        shift_en = !halt && !start && bit_rise && oe && (bits_left != '0);
    end

    // Drive-enable window and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_left <= '0;
            oe        <= 1'b0;
        end else if (halt) begin
            bits_left <= '0;
            oe        <= 1'b0;
        end else if (start) begin
            bits_left <= CW'(W - 1);
            oe        <= 1'b1;
        end else if (bit_rise && oe) begin
            if (bits_left == '0) begin
                oe <= 1'b0;
            end else begin
                bits_left <= bits_left - CW'(1);
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [W-1:0] shreg;

        // Per-channel output shift register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= '0;
            end else if (load_en) begin
                shreg <= thr_en ? cap_word[c] : proc_word[c];
            end else if (shift_en) begin
                shreg <= {shreg[W-2:0], 1'b0};
            end
        end

        assign sout[c] = shreg[W-1];
    end
endmodule

// File: rtl/pcm_serial_port.sv
// Module: top of the dual-channel PCM serial port. Synchronises the bit clock
// and frame sync, derives bit-clock edges and frame start in the system clock
// domain, and joins the capture and send halves. Assumes each bit-clock phase
// lasts at least three system-clock periods.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int DATA_W      = PCM_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_req,
    input  logic              bit_clk,
    input  logic              frame_sync,
    input  logic              through_en,
    input  logic              ser_in_a,
    input  logic              ser_in_b,
    input  logic [DATA_W-1:0] proc_a,
    input  logic [DATA_W-1:0] proc_b,
    output logic [DATA_W-1:0] par_a,
    output logic [DATA_W-1:0] par_b,
    output logic              load_stb,
    output logic              ser_out_a,
    output logic              ser_out_b,
    output logic              ser_oe
);
    localparam int NCH = PCM_NCH;

    logic [1:0]                    sync_lvls;
    logic                          bclk_lvl;
    logic                          fsync_lvl;
    logic                          bclk_prev;
    logic                          fsync_prev;
    logic                          bclk_rise;
    logic                          bclk_fall;
    logic                          frame_start;
    logic [NCH-1:0][DATA_W-1:0]    cap_words;
    logic [NCH-1:0][DATA_W-1:0]    proc_words;
    logic [NCH-1:0]                sin_bits;
    logic [NCH-1:0]                sout_bits;

    pcm_sync_chain #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({frame_sync, bit_clk}),
        .sync_out (sync_lvls)
    );

    assign bclk_lvl  = sync_lvls[0];
    assign fsync_lvl = sync_lvls[1];

    // Remember the bit-clock level, and the sync level seen at each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_prev  <= 1'b0;
            fsync_prev <= 1'b0;
        end else begin
            bclk_prev <= bclk_lvl;
            if (bclk_rise) begin
                fsync_prev <= fsync_lvl;
            end
        end
    end

    // Edge events and frame start (sync newly high at a rise).
    always_comb begin
        bclk_rise   = bclk_lvl && !bclk_prev;
        bclk_fall   = !bclk_lvl && bclk_prev;
        frame_start = bclk_rise && fsync_lvl && !fsync_prev;
    end

    assign sin_bits   = {ser_in_b, ser_in_a};
    assign proc_words = {proc_b, proc_a};

    pcm_rx_deser #(
        .W   (DATA_W),
        .NCH (NCH)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (pd_req),
        .start    (frame_start),
        .bit_fall (bclk_fall),
        .sin      (sin_bits),
        .par_out  (cap_words),
        .load_stb (load_stb)
    );

    pcm_tx_ser #(
        .W   (DATA_W),
        .NCH (NCH)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (pd_req),
        .start     (frame_start),
        .bit_rise  (bclk_rise),
        .thr_en    (through_en),
        .proc_word (proc_words),
        .cap_word  (cap_words),
        .sout      (sout_bits),
        .oe        (ser_oe)
    );

    assign par_a     = cap_words[0];
    assign par_b     = cap_words[1];
    assign ser_out_a = sout_bits[0];
    assign ser_out_b = sout_bits[1];
endmodule

// File: rtl/pcm_serial_port_chk.sv
// Module: assertion checker for pcm_serial_port, attached by bind.
// Relates the port behaviour to the synchronised bit-clock edge events.
module pcm_serial_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_req,
    input logic              bclk_rise,
    input logic              bclk_fall,
    input logic [DATA_W-1:0] par_a,
    input logic [DATA_W-1:0] par_b,
    input logic              load_stb,
    input logic              ser_out_a,
    input logic              ser_out_b,
    input logic              ser_oe
);
    // R1: reset releases the lines and clears the strobe.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!ser_oe && !load_stb));

    // R9: power-down silences outputs one clock later.
    assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> (!ser_oe && !load_stb));

    // R4: parallel words move only together with a strobe rise.
    assert_par_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(load_stb) |-> ($stable(par_a) && $stable(par_b)));

    // R6: output data and enable change only on a bit-clock rise.
    assert_out_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_rise && !pd_req) |=> ($stable(ser_oe) && $stable(ser_out_a) && $stable(ser_out_b)));

    // R3: the strobe changes only on a bit-clock fall.
    assert_stb_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_fall && !pd_req) |=> $stable(load_stb));
endmodule

bind pcm_serial_port pcm_serial_port_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .par_a     (par_a),
    .par_b     (par_b),
    .load_stb  (load_stb),
    .ser_out_a (ser_out_a),
    .ser_out_b (ser_out_b),
    .ser_oe    (ser_oe)
);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req = 1'b0;
    logic       bit_clk = 1'b0;
    logic       frame_sync = 1'b0;
    logic       through_en = 1'b0;
    logic       ser_in_a = 1'b0;
    logic       ser_in_b = 1'b0;
    logic [7:0] proc_a = '0;
    logic [7:0] proc_b = '0;
    logic [7:0] par_a, par_b;
    logic       load_stb, ser_out_a, ser_out_b, ser_oe;

    int checks = 0;
    int errors = 0;
    int h = 8;                 // bit-clock half period in system clocks
    logic [7:0] cap_a = '0;    // model of last captured bytes
    logic [7:0] cap_b = '0;
    int stb_run = 0;
    int stb_last = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;      // 250 MHz

    pcm_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .bit_clk(bit_clk),
        .frame_sync(frame_sync), .through_en(through_en),
        .ser_in_a(ser_in_a), .ser_in_b(ser_in_b), .proc_a(proc_a), .proc_b(proc_b),
        .par_a(par_a), .par_b(par_b), .load_stb(load_stb),
        .ser_out_a(ser_out_a), .ser_out_b(ser_out_b), .ser_oe(ser_oe)
    );

    // Measure the width of each strobe pulse in system clocks.
    always @(posedge clk) begin
        if (load_stb) stb_run <= stb_run + 1;
        else if (stb_run != 0) begin
            stb_last <= stb_run;
            stb_run  <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_fall(input logic s);
        bit_clk = 1'b0;
        frame_sync = s;
        repeat (h) @(negedge clk);
    endtask

    task automatic do_rise(input logic da, input logic db);
        bit_clk = 1'b1;
        ser_in_a = da;
        ser_in_b = db;
        repeat (h) @(negedge clk);
    endtask

    function automatic logic [7:0] pick(input bit thr, input logic [7:0] cap, input logic [7:0] prc);
        return thr ? cap : prc;
    endfunction

    task automatic run_frame(input logic [7:0] ia, input logic [7:0] ib,
                             input logic [7:0] pa, input logic [7:0] pb,
                             input bit thr, input int nb, input int sync_bits,
                             input int pd_at);
        logic [7:0] ea, eb;
        bit aborted;
        proc_a = pa;
        proc_b = pb;
        through_en = thr;
        ea = pick(thr, cap_a, pa);
        eb = pick(thr, cap_b, pb);
        aborted = 1'b0;
        for (int i = 0; i <= nb; i++) begin
            do_fall(i < sync_bits);
            if (i == 0)
                chk(par_a == cap_a && par_b == cap_b, "R4", "par held",
                    {par_a, par_b}, {cap_a, cap_b});
            if (i == 8) begin
                if (aborted) begin
                    chk(!load_stb, "R9", "no strobe after abort", load_stb, 0);
                    chk(par_a == cap_a && par_b == cap_b, "R9", "par unchanged",
                        {par_a, par_b}, {cap_a, cap_b});
                end else begin
                    chk(load_stb, "R3", "strobe high after bit 0", load_stb, 1);
                    chk(par_a == ia && par_b == ib, "R2", "captured bytes",
                        {par_a, par_b}, {ia, ib});
                    cap_a = ia;
                    cap_b = ib;
                end
            end
            if (i == 9)
                chk(!load_stb, "R3", "strobe low next fall", load_stb, 0);
            if (i == 10 && !aborted)
                chk(stb_last == 2 * h, "R3", "strobe width", stb_last, 2 * h);
            if (i == nb) break;
            do_rise(i < 8 ? ia[7-i] : 1'b0, i < 8 ? ib[7-i] : 1'b0);
            if (i < 8 && !aborted) begin
                chk(ser_oe, "R6", "oe in data bit", ser_oe, 1);
                chk(ser_out_a == ea[7-i] && ser_out_b == eb[7-i],
                    thr ? "R8" : "R6", "bit value",
                    {ser_out_a, ser_out_b}, {ea[7-i], eb[7-i]});
            end else begin
                chk(!ser_oe, aborted ? "R9" : "R7", "oe low outside data", ser_oe, 0);
            end
            if (i == pd_at) begin
                pd_req = 1'b1;
                @(negedge clk);
                chk(!ser_oe && !load_stb, "R9", "pd quiet", {ser_oe, load_stb}, 0);
                aborted = 1'b1;
            end
        end
        pd_req = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        chk(!ser_oe && !load_stb, "R1", "in reset", {ser_oe, load_stb}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!ser_oe && !load_stb && par_a == 0 && par_b == 0, "R1", "after reset",
            {ser_oe, load_stb, par_a, par_b}, 0);

        // Directed: basic frame, FF capture then pass-through (R8).
        h = 8;
        run_frame(8'hA5, 8'h3C, 8'h81, 8'h7E, 1'b0, 10, 1, -1);
        run_frame(8'hFF, 8'hFF, 8'h00, 8'h12, 1'b0, 10, 1, -1);
        run_frame(8'h00, 8'h7F, 8'h55, 8'hAA, 1'b1, 11, 1, -1);   // R8 sends FF/FF
        run_frame(8'h11, 8'h22, 8'hC3, 8'h3C, 1'b1, 10, 1, -1);   // R8 sends 00/7F
        // R5: sync held for two bit periods does not restart the frame.
        run_frame(8'h96, 8'h69, 8'hF0, 8'h0F, 1'b0, 10, 2, -1);
        // R9: power-down in the middle of a frame, then recovery.
        run_frame(8'hDE, 8'hAD, 8'hBE, 8'hEF, 1'b0, 10, 1, 3);
        run_frame(8'h5A, 8'hC7, 8'h24, 8'h42, 1'b0, 10, 1, -1);
        // R10: minimum phase length.
        h = 3;
        run_frame(8'hE7, 8'h18, 8'h99, 8'h66, 1'b0, 12, 1, -1);

        // Random frames at random bit-clock ratios (R10).
        for (int f = 0; f < 24; f++) begin
            h = 3 + int'($urandom_range(5));
            run_frame(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                      ($urandom_range(3) == 0), 10 + int'($urandom_range(2)), 1, -1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule